// File: doc/BRIEF.md
# Register Timing Violation Checker

This block sits at the end of a levelized, delay-annotated logic evaluation step. At every simulated cycle boundary each state word arrives with its worst-case arrival time, in picoseconds. The block tests that time against the word's setup and hold limits and against the clock period. For every rule that is broken, it produces a typed event record.

Check requests come in on a valid/ready input. Each request carries the arrival, a 32-bit packed limit word, the period, the cycle number and the word's index. Records leave on a valid/ready output. Each record carries the event kind, the cycle, the index, a signed slack, the arrival and the limit that was broken. One word can break both rules in the same cycle. In that case the block sends two records, setup first and then hold, and stops taking new requests until the second record has been queued.

The event-kind numbering is shared with other event producers. Codes 0 to 3 are reserved for stop, finish, display and assertion failure. This block emits only code 4 (setup) and code 5 (hold).

Top module: `vio_checker`

## Requirements
- R1: After a synchronous reset, `ev_valid` is 0 and `chk_ready` is 1.
- R2: The limit word `chk_limits` holds the setup time in bits 31:16 and the hold time in bits 15:0. Both are unsigned picosecond values.
- R3: The sum of arrival and setup is formed without overflow. For example, arrival 0xFFFF with setup 0xFFFF against period 0x1FFFD is a setup violation. A sum exactly equal to the period is not a violation.
- R4: A setup record has kind 4, slack = period − arrival − setup as a signed 33-bit value, and limit = setup.
- R5: A setup violation is reported only when the arrival is non-zero and arrival + setup > period. A zero arrival never produces a setup record.
- R6: A hold violation is reported whenever arrival < hold, including when the arrival is zero. Its record has kind 5, slack = arrival − hold (signed), and limit = hold. Arrival equal to hold is not a violation.
- R7: When a word breaks both rules, the setup record is emitted before the hold record. Every record carries the request's cycle, index and arrival unchanged.
- R8: While `ev_valid` is 1 and `ev_ready` is 0, the output record stays valid and unchanged on the next cycle.
- R9: `chk_ready` is 0 while an output record is stalled or while a second record is still waiting. No accepted violation is lost.
- R10: A request that breaks neither rule produces no record.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| chk_valid | input | 1 | Check request present |
| chk_ready | output | 1 | Request accepted this cycle when valid |
| chk_arrival | input | 16 | Arrival time of the word, ps |
| chk_limits | input | 32 | Setup in 31:16, hold in 15:0, ps |
| chk_period | input | 32 | Clock period, ps |
| chk_cycle | input | 32 | Cycle number of the request |
| chk_index | input | 16 | State word index |
| ev_valid | output | 1 | Event record present |
| ev_ready | input | 1 | Consumer takes the record |
| ev_kind | output | 3 | Event kind, 4 setup, 5 hold |
| ev_cycle | output | 32 | Cycle of the violation |
| ev_index | output | 16 | Word index of the violation |
| ev_slack | output | 33 | Signed slack, ps |
| ev_arrival | output | 16 | Arrival that was checked |
| ev_limit | output | 16 | Setup or hold limit that was broken |

## Verification
Some rules hold on every cycle regardless of stimulus, and the assertions check those. A stalled record holds still. The input is refused while the output is stalled. Every record has kind 4 or 5 and a negative slack. A setup record never carries a zero arrival, and a hold record's arrival is always below its limit. Other behaviour needs the bench's scenarios to show it: the exact slack arithmetic, the equality boundaries, the overflow case, setup-before-hold ordering, and the absence of any record for clean words. The bench checks these against a scoreboard under both free-flowing and throttled consumers.

// File: rtl/vio_pkg.sv
package vio_pkg;
  typedef enum logic [2:0] {
    EV_STOP    = 3'd0,
    EV_FINISH  = 3'd1,
    EV_DISPLAY = 3'd2,
    EV_ASSERT  = 3'd3,
    EV_SETUP   = 3'd4,
    EV_HOLD    = 3'd5
  } ev_kind_e;
endpackage

// File: rtl/vio_eval.sv
module vio_eval #(
  parameter int TW = 16,
  parameter int PW = 32,
  localparam int SLW = PW + 1
) (
  input  logic [TW-1:0]    arrival,
  input  logic [2*TW-1:0]  limits,
  input  logic [PW-1:0]    period,
  output logic             setup_hit,
  output logic             hold_hit,
  output logic [SLW-1:0]   setup_slack,
  output logic [SLW-1:0]   hold_slack,
  output logic [TW-1:0]    setup_lim,
  output logic [TW-1:0]    hold_lim
);
  logic [PW-1:0]  sum_w;
  logic [SLW-1:0] arr_x, set_x, hld_x, per_x;

  always_comb begin
    setup_lim   = limits[2*TW-1:TW];
    hold_lim    = limits[TW-1:0];
    sum_w       = PW'(arrival) + PW'(setup_lim);
    arr_x       = SLW'(arrival);
    set_x       = SLW'(setup_lim);
    hld_x       = SLW'(hold_lim);
    per_x       = SLW'(period);
    setup_hit   = (arrival != '0) && (sum_w > period);
    hold_hit    = arrival < hold_lim;
    setup_slack = per_x - arr_x - set_x;
    hold_slack  = arr_x - hld_x;
  end
endmodule

// File: rtl/vio_emit.sv
module vio_emit #(
  parameter int RW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          take,
  input  logic          first_hit,
  input  logic [RW-1:0] first_rec,
  input  logic          second_hit,
  input  logic [RW-1:0] second_rec,
  output logic          can_take,
  output logic          out_v,
  output logic [RW-1:0] out_rec,
  input  logic          out_rdy
);
  logic          pend_v;
  logic [RW-1:0] pend_rec;
  logic          slot_free;

  assign slot_free = !out_v || out_rdy;
  assign can_take  = !pend_v && slot_free;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_v    <= 1'b0;
      pend_v   <= 1'b0;
      out_rec  <= '0;
      pend_rec <= '0;
    end else begin
      if (out_v && out_rdy) out_v <= 1'b0;
      if (pend_v && slot_free) begin
        out_v   <= 1'b1;
        out_rec <= pend_rec;
        pend_v  <= 1'b0;
      end else if (take) begin
        if (first_hit) begin
          out_v   <= 1'b1;
          out_rec <= first_rec;
          if (second_hit) begin
            pend_v   <= 1'b1;
            pend_rec <= second_rec;
          end
        end else if (second_hit) begin
          out_v   <= 1'b1;
          out_rec <= second_rec;
        end
      end
    end
  end
endmodule

// File: rtl/vio_checker.sv
module vio_checker #(
  parameter int TW = 16,
  parameter int PW = 32,
  parameter int CW = 32,
  parameter int IW = 16,
  localparam int SLW = PW + 1,
  localparam int RW  = 3 + CW + IW + SLW + 2 * TW
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            chk_valid,
  output logic            chk_ready,
  input  logic [TW-1:0]   chk_arrival,
  input  logic [2*TW-1:0] chk_limits,
  input  logic [PW-1:0]   chk_period,
  input  logic [CW-1:0]   chk_cycle,
  input  logic [IW-1:0]   chk_index,
  output logic            ev_valid,
  input  logic            ev_ready,
  output logic [2:0]      ev_kind,
  output logic [CW-1:0]   ev_cycle,
  output logic [IW-1:0]   ev_index,
  output logic [SLW-1:0]  ev_slack,
  output logic [TW-1:0]   ev_arrival,
  output logic [TW-1:0]   ev_limit
);
  import vio_pkg::*;

  logic           s_hit, h_hit;
  logic [SLW-1:0] s_slack, h_slack;
  logic [TW-1:0]  s_lim, h_lim;
  logic [RW-1:0]  s_rec, h_rec, o_rec;
  logic           take;

  vio_eval #(.TW(TW), .PW(PW)) u_eval (
    .arrival     (chk_arrival),
    .limits      (chk_limits),
    .period      (chk_period),
    .setup_hit   (s_hit),
    .hold_hit    (h_hit),
    .setup_slack (s_slack),
    .hold_slack  (h_slack),
    .setup_lim   (s_lim),
    .hold_lim    (h_lim)
  );

  assign s_rec = {EV_SETUP, chk_cycle, chk_index, s_slack, chk_arrival, s_lim};
  assign h_rec = {EV_HOLD,  chk_cycle, chk_index, h_slack, chk_arrival, h_lim};
  assign take  = chk_valid && chk_ready;

  vio_emit #(.RW(RW)) u_emit (
    .clk        (clk),
    .rst        (rst),
    .take       (take),
    .first_hit  (s_hit),
    .first_rec  (s_rec),
    .second_hit (h_hit),
    .second_rec (h_rec),
    .can_take   (chk_ready),
    .out_v      (ev_valid),
    .out_rec    (o_rec),
    .out_rdy    (ev_ready)
  );

  assign {ev_kind, ev_cycle, ev_index, ev_slack, ev_arrival, ev_limit} = o_rec;
endmodule

// File: rtl/vio_checker_sva.sv
module vio_checker_sva #(
  parameter int TW = 16,
  parameter int PW = 32,
  parameter int CW = 32,
  parameter int IW = 16,
  localparam int SLW = PW + 1
) (
  input logic           clk,
  input logic           rst,
  input logic           chk_ready,
  input logic           ev_valid,
  input logic           ev_ready,
  input logic [2:0]     ev_kind,
  input logic [CW-1:0]  ev_cycle,
  input logic [IW-1:0]  ev_index,
  input logic [SLW-1:0] ev_slack,
  input logic [TW-1:0]  ev_arrival,
  input logic [TW-1:0]  ev_limit
);
  p_hold_stall_r8: assert property (@(posedge clk) disable iff (rst)
    ev_valid && !ev_ready |=> ev_valid && $stable(ev_kind) && $stable(ev_cycle)
      && $stable(ev_index) && $stable(ev_slack) && $stable(ev_arrival) && $stable(ev_limit));

  p_backpressure_r9: assert property (@(posedge clk) disable iff (rst)
    ev_valid && !ev_ready |-> !chk_ready);

  p_kind_r7: assert property (@(posedge clk) disable iff (rst)
    ev_valid |-> (ev_kind == 3'd4 || ev_kind == 3'd5));

  p_setup_neg_r4: assert property (@(posedge clk) disable iff (rst)
    ev_valid && ev_kind == 3'd4 |-> ev_slack[SLW-1]);

  p_setup_guard_r5: assert property (@(posedge clk) disable iff (rst)
    ev_valid && ev_kind == 3'd4 |-> ev_arrival != '0);

  p_hold_rule_r6: assert property (@(posedge clk) disable iff (rst)
    ev_valid && ev_kind == 3'd5 |-> ev_arrival < ev_limit && ev_slack[SLW-1]);
endmodule

bind vio_checker vio_checker_sva #(.TW(TW), .PW(PW), .CW(CW), .IW(IW)) u_sva (
  .clk(clk), .rst(rst), .chk_ready(chk_ready), .ev_valid(ev_valid),
  .ev_ready(ev_ready), .ev_kind(ev_kind), .ev_cycle(ev_cycle),
  .ev_index(ev_index), .ev_slack(ev_slack), .ev_arrival(ev_arrival),
  .ev_limit(ev_limit)
);

// File: tb/sim_vio_checker.sv
module sim_vio_checker;
  logic        clk = 0;
  logic        rst = 1;
  logic        chk_valid = 0;
  logic        chk_ready;
  logic [15:0] chk_arrival = 0;
  logic [31:0] chk_limits = 0;
  logic [31:0] chk_period = 0;
  logic [31:0] chk_cycle = 0;
  logic [15:0] chk_index = 0;
  logic        ev_valid;
  logic        ev_ready = 1;
  logic [2:0]  ev_kind;
  logic [31:0] ev_cycle;
  logic [15:0] ev_index;
  logic [32:0] ev_slack;
  logic [15:0] ev_arrival;
  logic [15:0] ev_limit;

  int total = 0;
  int fails = 0;
  int throttle = 0;
  int tick = 0;

  typedef struct {
    int     kind;
    longint cyc;
    longint idx;
    longint slack;
    longint arr;
    longint lim;
  } exp_t;
  exp_t q[$];

  always #4 clk = ~clk;

  vio_checker u0 (
    .clk(clk), .rst(rst), .chk_valid(chk_valid), .chk_ready(chk_ready),
    .chk_arrival(chk_arrival), .chk_limits(chk_limits), .chk_period(chk_period),
    .chk_cycle(chk_cycle), .chk_index(chk_index), .ev_valid(ev_valid),
    .ev_ready(ev_ready), .ev_kind(ev_kind), .ev_cycle(ev_cycle),
    .ev_index(ev_index), .ev_slack(ev_slack), .ev_arrival(ev_arrival),
    .ev_limit(ev_limit)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Scoreboard push: expected records derived from R2..R7, R10
  task automatic send(input logic [15:0] a, input logic [31:0] lim,
                      input logic [31:0] per, input logic [31:0] cyc,
                      input logic [15:0] idx);
    longint st, hd, sum;
    exp_t e;
    bit rdy;
    st  = longint'(lim[31:16]);
    hd  = longint'(lim[15:0]);
    sum = longint'(a) + st;
    e.cyc = cyc; e.idx = idx; e.arr = a;
    if (a != 0 && sum > longint'(per)) begin
      e.kind = 4; e.slack = longint'(per) - sum; e.lim = st;
      q.push_back(e);
    end
    if (longint'(a) < hd) begin
      e.kind = 5; e.slack = longint'(a) - hd; e.lim = hd;
      q.push_back(e);
    end
    @(negedge clk);
    chk_valid = 1; chk_arrival = a; chk_limits = lim;
    chk_period = per; chk_cycle = cyc; chk_index = idx;
    forever begin
      #1 rdy = chk_ready;
      @(posedge clk);
      if (rdy) break;
      @(negedge clk);
    end
    @(negedge clk);
    chk_valid = 0;
  endtask

  // Monitor: drives ev_ready, pops and compares on each handshake
  initial begin
    bit held = 0;
    logic [2:0]  hk; logic [31:0] hc; logic [15:0] hi, ha, hl; logic [32:0] hs;
    exp_t e;
    @(negedge clk);
    while (rst) @(negedge clk);
    forever begin
      @(negedge clk);
      tick++;
      ev_ready = (throttle == 0) ? 1'b1 : ((tick % 3) == 0);
      if (held) begin
        check(ev_valid && ev_kind == hk && ev_cycle == hc && ev_index == hi &&
              ev_slack == hs && ev_arrival == ha && ev_limit == hl,
              "R8", "stalled record changed", longint'(ev_kind), longint'(hk));
      end
      #1;
      if (ev_valid && !ev_ready)
        check(!chk_ready, "R9", "chk_ready while stalled", chk_ready, 0);
      held = ev_valid && !ev_ready;
      hk = ev_kind; hc = ev_cycle; hi = ev_index; hs = ev_slack; ha = ev_arrival; hl = ev_limit;
      if (ev_valid && ev_ready) begin
        if (q.size() == 0) begin
          check(0, "R10", "unexpected record kind", longint'(ev_kind), -1);
        end else begin
          e = q.pop_front();
          check(int'(ev_kind) == e.kind, "R7", "kind/order", ev_kind, e.kind);
          check(longint'(ev_cycle) == e.cyc && longint'(ev_index) == e.idx &&
                longint'(ev_arrival) == e.arr, "R7", "cycle/index/arrival",
                longint'(ev_index), e.idx);
          check(longint'($signed(ev_slack)) == e.slack,
                e.kind == 4 ? "R4" : "R6", "slack",
                longint'($signed(ev_slack)), e.slack);
          check(longint'(ev_limit) == e.lim, "R2", "limit field",
                longint'(ev_limit), e.lim);
        end
      end
    end
  end

  task automatic drain();
    int n = 0;
    while ((q.size() != 0 || ev_valid) && n < 500) begin
      @(negedge clk); n++;
    end
    repeat (4) @(negedge clk);
    check(q.size() == 0, "R9", "records lost", q.size(), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++; total++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    logic [31:0] x = 32'h1234_5678;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 0;
    #1;
    // R1
    check(ev_valid == 0, "R1", "ev_valid after reset", ev_valid, 0);
    check(chk_ready == 1, "R1", "chk_ready after reset", chk_ready, 1);

    // R10: clean word
    send(16'd100, {16'd20, 16'd10}, 32'd1000, 32'd1, 16'd3);
    // R4/R5: setup only
    send(16'd900, {16'd150, 16'd10}, 32'd1000, 32'd2, 16'd4);
    // R6: zero arrival, hold fires in cycle 0, setup suppressed (R5)
    send(16'd0, {16'hFFFF, 16'd25}, 32'd10, 32'd0, 16'd5);
    // R5: zero arrival, no hold limit, nothing at all
    send(16'd0, {16'hFFFF, 16'd0}, 32'd1, 32'd0, 16'd6);
    // R7: both rules broken -> setup then hold
    send(16'd50, {16'd80, 16'd60}, 32'd100, 32'd7, 16'd7);
    // R3: overflow-free sum, fires at period 0x1FFFD, not at 0x1FFFE
    send(16'hFFFF, {16'hFFFF, 16'd0}, 32'h1FFFD, 32'd8, 16'd8);
    send(16'hFFFF, {16'hFFFF, 16'd0}, 32'h1FFFE, 32'd9, 16'd9);
    // R3/R6 boundaries: sum == period, arrival == hold
    send(16'd400, {16'd600, 16'd400}, 32'd1000, 32'd10, 16'd10);
    drain();

    // R8/R9: throttled consumer with a stream of double violations
    throttle = 1;
    for (int i = 0; i < 6; i++)
      send(16'(10 + i), {16'd200, 16'd50}, 32'd100, 32'(20 + i), 16'(i));
    drain();

    // mixed patterns under both consumer modes
    for (int i = 0; i < 60; i++) begin
      throttle = i & 1;
      x = x ^ (x << 13); x = x ^ (x >> 17); x = x ^ (x << 5);
      send({6'd0, x[9:0]}, {6'd0, x[19:10], 10'd0, x[29:20] >> 2},
           32'd600 + {24'd0, x[31:24]}, 32'(100 + i), x[15:0]);
    end
    drain();

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule